// File: doc/BRIEF.md
# Phase-Shifted Carrier Multilevel PWM

This block produces the switch commands for one phase built from several full-bridge cells in series (three by default). One signed reference word feeds every cell. Each cell has its own triangular carrier, and the carriers are spread evenly across one carrier period. With three cells the spacing is 120 degrees, so the summed phase voltage steps through seven levels. The effective switching rate is also three times that of any one cell.

Each cell has two legs. The first leg compares the held reference against the cell's bipolar carrier. The second leg compares the negated reference against the same carrier. The two legs together select the cell's +1, 0 or -1 state. Each switch command passes through a dead-time stage before it reaches its gate output. That stage delays a turn-on by a programmable number of clock cycles and lets a turn-off through at once. A registered signed level gives the commanded sum of the cell states.

Each carrier is a two-state machine. State RISE counts up and moves to FALL when the count reaches the peak. State FALL counts down and returns to RISE when it steps from 1 to 0. Each gate stage is a three-state machine:
- OFF moves to ON if the command appears while the dead time is zero. Otherwise it moves to WAIT.
- WAIT moves to ON once the dead time has elapsed, and back to OFF if the command drops.
- ON moves to OFF as soon as the command drops.

Top module: `pscm_top`

## Requirements
- R1: The gate bus holds one nibble per cell: bit 0 S1, bit 1 S2, bit 2 S3, bit 3 S4. In steady state the cell state +1 drives nibble 4'b0011 and the state -1 drives 4'b1100. The zero state has exactly one switch of each leg on.
- R2: S1 and S3 are never on together, and S2 and S4 are never on together.
- R3: Each cell holds the reference in a private register. That register loads on the cell's carrier peak (count equal to `car_peak`) and continuously while `en` is low. A reference change has no effect on a cell until its next peak.
- R4: Let c be the cell's carrier count, P the value of `car_peak`, and b = 2c - P. S1 is commanded when the held reference is greater than b, and S3 otherwise. S4 is commanded when the negated reference is greater than b, and S2 otherwise.
- R5: Each carrier runs 0, 1, ..., P, P-1, ..., 1 and repeats, so its period is 2P cycles. While `en` is low, cell k is preset to phase position k*floor(2P/CELLS) of that sequence. With P=12 and three cells, successive cells reach their peaks 8 cycles apart.
- R6: A gate rises `dead_cyc` clock edges after its command appears, and falls on the same edge on which its command drops.
- R7: `level_o` is the sum of the commanded cell states, where S1&S2 counts +1, S3&S4 counts -1 and any other pairing counts 0. It is registered on the same edge as the commands, and its range is -CELLS to +CELLS.
- R8: One edge after `en` is sampled low, all gates are 0 and `level_o` is 0. Both are 0 after reset.
- R9: A reference above P holds every cell at +1, so the level is +CELLS. A reference below -P gives -CELLS. A reference of 0 keeps the level at 0 on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run enable; low presets carriers and turns all gates off |
| ref_in | input | CW+1 | Signed reference sample shared by all cells |
| car_peak | input | CW | Carrier peak count P (half of the carrier period) |
| dead_cyc | input | DTW | Turn-on delay in clock cycles |
| gate_o | output | 4*CELLS | Gate drives, one nibble per cell |
| level_o | output | LW | Signed sum of the commanded cell states |

## Verification
`level_o` is due one edge after the edge that changes a command. That edge is either the first edge with `en` high or the edge just after a carrier peak. A gate is due `dead_cyc` edges later, or on that same edge when it turns off. The bench drives inputs and samples outputs on falling clock edges. For each reference it integrates the level over exactly one full carrier period, starting on the first sample after enable. It counts the edges between level steps to confirm the 8-cycle peak spacing. It checks gate turn-on on the exact edge that `dead_cyc` names, and a monitor requires every gate rise to follow at least `dead_cyc` low samples of its partner switch.

// File: rtl/pscm_pkg.sv
package pscm_pkg;
    typedef enum logic {CAR_RISE, CAR_FALL} car_dir_e;
    typedef enum logic [1:0] {DB_OFF, DB_WAIT, DB_ON} db_state_e;
endpackage

// File: rtl/pscm_carrier.sv
module pscm_carrier
    import pscm_pkg::*;
#(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [CW-1:0] car_peak,
    input  logic [CW-1:0] pre_cnt,
    input  car_dir_e      pre_dir,
    output logic [CW-1:0] cnt,
    output logic          at_peak
);
    car_dir_e      dir, dir_nx;
    logic [CW-1:0] cnt_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir <= CAR_RISE;
            cnt <= '0;
        end else if (!en) begin
            dir <= pre_dir;
            cnt <= pre_cnt;
        end else begin
            dir <= dir_nx;
            cnt <= cnt_nx;
        end
    end

    always_comb begin
        dir_nx = dir;
        cnt_nx = cnt;
        unique case (dir)
            CAR_RISE: begin
                if (cnt >= car_peak) begin
                    dir_nx = CAR_FALL;
                    cnt_nx = car_peak - 1'b1;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
            CAR_FALL: begin
                if (cnt <= 1) begin
                    dir_nx = CAR_RISE;
                    cnt_nx = '0;
                end else begin
                    cnt_nx = cnt - 1'b1;
                end
            end
        endcase
    end

    assign at_peak = (dir == CAR_RISE) && (cnt == car_peak);
endmodule

// File: rtl/pscm_deadband.sv
module pscm_deadband
    import pscm_pkg::*;
#(
    parameter int DTW = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd,
    input  logic [DTW-1:0] dead_cyc,
    output logic           gate
);
    db_state_e      st, st_nx;
    logic [DTW-1:0] wait_cnt, wait_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= DB_OFF;
            wait_cnt <= '0;
        end else begin
            st       <= st_nx;
            wait_cnt <= wait_nx;
        end
    end

    always_comb begin
        st_nx   = st;
        wait_nx = wait_cnt;
        unique case (st)
            DB_OFF: begin
                if (cmd) begin
                    st_nx   = (dead_cyc == '0) ? DB_ON : DB_WAIT;
                    wait_nx = DTW'(1);
                end
            end
            DB_WAIT: begin
                if (!cmd) begin
                    st_nx   = DB_OFF;
                    wait_nx = '0;
                end else if (wait_cnt >= dead_cyc) begin
                    st_nx = DB_ON;
                end else begin
                    wait_nx = wait_cnt + 1'b1;
                end
            end
            DB_ON: begin
                if (!cmd) begin
                    st_nx   = DB_OFF;
                    wait_nx = '0;
                end
            end
            default: begin
                st_nx   = DB_OFF;
                wait_nx = '0;
            end
        endcase
    end

    assign gate = (st == DB_ON);
endmodule

// File: rtl/pscm_cell.sv
module pscm_cell #(
    parameter int CW  = 10,
    parameter int DTW = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic signed [CW:0]  ref_in,
    input  logic [CW-1:0]       car_peak,
    input  logic [CW-1:0]       car_cnt,
    input  logic                at_peak,
    input  logic [DTW-1:0]      dead_cyc,
    output logic [3:0]          gate,
    output logic signed [1:0]   st
);
    localparam int PW = CW + 2;

    logic signed [CW:0]   held;
    logic signed [PW-1:0] bip, pos_ref, neg_ref;
    logic                 above_a, above_b;
    logic [3:0]           cmd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             held <= '0;
        else if (!en || at_peak) held <= ref_in;
    end

    assign bip     = $signed({1'b0, car_cnt, 1'b0}) - $signed({2'b00, car_peak});
    assign pos_ref = {held[CW], held};
    assign neg_ref = -pos_ref;
    assign above_a = pos_ref > bip;
    assign above_b = neg_ref > bip;

    assign cmd[0] = en &  above_a;
    assign cmd[2] = en & ~above_a;
    assign cmd[1] = en & ~above_b;
    assign cmd[3] = en &  above_b;

    always_comb begin
        if (cmd[0] && cmd[1])      st = 2'sd1;
        else if (cmd[2] && cmd[3]) st = -2'sd1;
        else                       st = 2'sd0;
    end

    for (genvar j = 0; j < 4; j++) begin : g_sw
        pscm_deadband #(.DTW(DTW)) u_db (
            .clk      (clk),
            .rst_n    (rst_n),
            .cmd      (cmd[j]),
            .dead_cyc (dead_cyc),
            .gate     (gate[j])
        );
    end
endmodule

// File: rtl/pscm_top.sv
module pscm_top
    import pscm_pkg::*;
#(
    parameter  int CELLS = 3,
    parameter  int CW    = 10,
    parameter  int DTW   = 6,
    localparam int LW    = $clog2(2*CELLS+1) + 1,
    localparam int GW    = 4*CELLS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic signed [CW:0]   ref_in,
    input  logic [CW-1:0]        car_peak,
    input  logic [DTW-1:0]       dead_cyc,
    output logic [GW-1:0]        gate_o,
    output logic signed [LW-1:0] level_o
);
    localparam int PW = CW + 2;

    logic [PW-1:0]         span, stride;
    logic signed [1:0]     cell_st [CELLS];
    logic [CELLS*CW-1:0]   car_cnt_flat;
    logic signed [LW-1:0]  lvl_nx;

    assign span   = {1'b0, car_peak, 1'b0};
    assign stride = span / PW'(CELLS);

    for (genvar k = 0; k < CELLS; k++) begin : g_cell
        logic [PW-1:0] pos;
        logic [CW-1:0] pre_cnt, cnt;
        car_dir_e      pre_dir;
        logic          at_peak;

        always_comb begin
            pos = PW'(k) * stride;
            if (pos <= {2'b00, car_peak}) begin
                pre_cnt = pos[CW-1:0];
                pre_dir = CAR_RISE;
            end else begin
                pre_cnt = CW'(span - pos);
                pre_dir = CAR_FALL;
            end
        end

        pscm_carrier #(.CW(CW)) u_car (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (en),
            .car_peak (car_peak),
            .pre_cnt  (pre_cnt),
            .pre_dir  (pre_dir),
            .cnt      (cnt),
            .at_peak  (at_peak)
        );

        pscm_cell #(.CW(CW), .DTW(DTW)) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (en),
            .ref_in   (ref_in),
            .car_peak (car_peak),
            .car_cnt  (cnt),
            .at_peak  (at_peak),
            .dead_cyc (dead_cyc),
            .gate     (gate_o[4*k +: 4]),
            .st       (cell_st[k])
        );

        assign car_cnt_flat[k*CW +: CW] = cnt;
    end

    always_comb begin
        lvl_nx = '0;
        for (int k = 0; k < CELLS; k++) begin
            lvl_nx = lvl_nx + $signed({{(LW-2){cell_st[k][1]}}, cell_st[k]});
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_o <= '0;
        else        level_o <= lvl_nx;
    end
endmodule

// File: rtl/pscm_chk.sv
module pscm_chk #(
    parameter int CELLS = 3,
    parameter int CW    = 10,
    parameter int DTW   = 6,
    parameter int LW    = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 en,
    input logic [CW-1:0]        car_peak,
    input logic [DTW-1:0]       dead_cyc,
    input logic [4*CELLS-1:0]   gate_o,
    input logic signed [LW-1:0] level_o,
    input logic [CELLS*CW-1:0]  car_cnt_flat
);
    logic [4*CELLS-1:0] gate_q, partner_q;
    logic               pair_clash, early_rise, cnt_over;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gate_q <= '0;
        else        gate_q <= gate_o;
    end

    always_comb begin
        pair_clash = 1'b0;
        cnt_over   = 1'b0;
        for (int i = 0; i < 4*CELLS; i++) begin
            partner_q[i] = gate_q[i ^ 2];
            if (gate_o[i] && gate_o[i ^ 2]) pair_clash = 1'b1;
        end
        for (int k = 0; k < CELLS; k++) begin
            if (car_cnt_flat[k*CW +: CW] > car_peak) cnt_over = 1'b1;
        end
        early_rise = |(gate_o & ~gate_q & partner_q);
    end

    // R2: complementary switches never conduct together
    a_r2_pair_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_clash);

    // R6: with a non-zero delay, no gate rises while its partner was on
    a_r6_dead_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (dead_cyc != '0 && $stable(dead_cyc)) |-> !early_rise);

    // R8: disable clears every output one edge later
    a_r8_idle_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (gate_o == '0 && level_o == '0));

    // R7: level within the number of cells
    a_r7_level_span: assert property (@(posedge clk) disable iff (!rst_n)
        (level_o >= -CELLS && level_o <= CELLS));

    // R5: carriers stay between zero and the peak
    a_r5_carrier_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $stable(car_peak)) |-> !cnt_over);
endmodule

bind pscm_top pscm_chk #(.CELLS(CELLS), .CW(CW), .DTW(DTW), .LW(LW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (en),
    .car_peak     (car_peak),
    .dead_cyc     (dead_cyc),
    .gate_o       (gate_o),
    .level_o      (level_o),
    .car_cnt_flat (car_cnt_flat)
);

// File: tb/pscm_top_bench.sv
module pscm_top_bench;
    localparam int CELLS = 3;
    localparam int CW    = 10;
    localparam int DTW   = 6;
    localparam int LW    = 4;
    localparam int P     = 12;
    localparam int NV    = 8;
    localparam int NOHOLD = 99;
    localparam int VEC_REF  [NV] = '{0, 5, -5, 12, 13, -13, 7, -12};
    localparam int VEC_HOLD [NV] = '{0, NOHOLD, NOHOLD, NOHOLD, 3, -3, NOHOLD, NOHOLD};

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 en = 1'b0;
    logic signed [CW:0]   ref_in = '0;
    logic [CW-1:0]        car_peak = CW'(P);
    logic [DTW-1:0]       dead_cyc = DTW'(2);
    logic [4*CELLS-1:0]   gate_o;
    logic signed [LW-1:0] level_o;

    int checks = 0, errors = 0, mchecks = 0, merrors = 0;
    bit done = 1'b0, mon_on = 1'b0;

    always #10 clk = ~clk;

    pscm_top #(.CELLS(CELLS), .CW(CW), .DTW(DTW)) u_pscm_top (
        .clk(clk), .rst_n(rst_n), .en(en), .ref_in(ref_in),
        .car_peak(car_peak), .dead_cyc(dead_cyc),
        .gate_o(gate_o), .level_o(level_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // Per-cycle cell state from the comparison rule, summed over one period
    function automatic int exp_sum(input int r);
        int s = 0;
        for (int q = 0; q < 2*P; q++) begin
            int c = (q <= P) ? q : 2*P - q;
            int b = 2*c - P;
            bit s1 = r > b;
            bit s2 = !(-r > b);
            if (s1 && s2)        s += 1;
            else if (!s1 && !s2) s -= 1;
        end
        return CELLS * s;
    endfunction

    // R2 / R6 monitor on every falling edge
    int low_run [4*CELLS];
    logic [4*CELLS-1:0] gprev = '0;
    initial for (int i = 0; i < 4*CELLS; i++) low_run[i] = 1000;
    always @(negedge clk) begin
        if (mon_on) begin
            mchecks++;
            for (int i = 0; i < 4*CELLS; i++) begin
                if (gate_o[i] && gate_o[i ^ 2]) begin
                    merrors++;
                    $display("FAIL R2: switch %0d and %0d both on, got 1 expected 0", i, i ^ 2);
                end
                if (gate_o[i] && !gprev[i]) begin
                    mchecks++;
                    if (low_run[i ^ 2] < int'(dead_cyc)) begin
                        merrors++;
                        $display("FAIL R6: switch %0d rose after partner low %0d, expected >= %0d",
                                 i, low_run[i ^ 2], dead_cyc);
                    end
                end
            end
        end
        for (int i = 0; i < 4*CELLS; i++)
            low_run[i] = gate_o[i] ? 0 : ((low_run[i] < 1000) ? low_run[i] + 1 : 1000);
        gprev = gate_o;
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks + mchecks, errors + merrors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not end, got 1 expected 0");
            finish_run();
        end
    end

    initial begin
        int win [2*P];
        int s, prev, steps, last, cyc;

        // R8: reset state
        repeat (3) @(negedge clk);
        chk(gate_o == '0, "R8 reset gates", int'(gate_o), 0);
        chk(level_o == 0, "R8 reset level", int'(level_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1'b1;

        // Vector table: R4 integral, R5 periodicity, R7 range, R9 holds, R1 nibbles
        for (int v = 0; v < NV; v++) begin
            en = 1'b0;
            ref_in = (CW+1)'(VEC_REF[v]);
            repeat (2) @(negedge clk);
            en = 1'b1;
            s = 0;
            for (int t = 0; t < 2*P; t++) begin
                @(negedge clk);
                win[t] = int'(level_o);
                s += win[t];
                if (win[t] < -CELLS || win[t] > CELLS)
                    chk(1'b0, "R7 level range", win[t], 0);
                if (VEC_HOLD[v] != NOHOLD && win[t] != VEC_HOLD[v])
                    chk(1'b0, "R9 steady level", win[t], VEC_HOLD[v]);
            end
            chk(s == exp_sum(VEC_REF[v]), "R4 level over one period", s, exp_sum(VEC_REF[v]));
            for (int t = 0; t < 2*P; t++) begin
                @(negedge clk);
                if (int'(level_o) != win[t])
                    chk(1'b0, "R5 period repeat", int'(level_o), win[t]);
            end
            chk(1'b1, "R5 period repeat", 0, 0);
            if (VEC_REF[v] > P)
                chk(gate_o == {CELLS{4'b0011}}, "R1 positive nibbles", int'(gate_o), int'({CELLS{4'b0011}}));
            if (VEC_REF[v] < -P)
                chk(gate_o == {CELLS{4'b1100}}, "R1 negative nibbles", int'(gate_o), int'({CELLS{4'b1100}}));
        end

        // R6: exact turn-on delay of 3 edges after enable
        en = 1'b0;
        dead_cyc = DTW'(3);
        ref_in = (CW+1)'(100);
        repeat (2) @(negedge clk);
        en = 1'b1;
        @(negedge clk);
        chk(level_o == CELLS, "R7 level on first enabled edge", int'(level_o), CELLS);
        chk(gate_o == '0, "R6 gates held after E0", int'(gate_o), 0);
        repeat (2) @(negedge clk);
        chk(gate_o == '0, "R6 gates held after E2", int'(gate_o), 0);
        @(negedge clk);
        chk(gate_o == {CELLS{4'b0011}}, "R6 gates on after E3", int'(gate_o), int'({CELLS{4'b0011}}));

        // R3 / R5: reference flips; cells follow one by one at their peaks
        ref_in = -(CW+1)'(100);
        prev = CELLS; steps = 0; last = 0; cyc = 0;
        for (int t = 0; t < 50; t++) begin
            @(negedge clk);
            cyc++;
            if (int'(level_o) != prev) begin
                steps++;
                chk(int'(level_o) == prev - 2, "R3 one cell per step", int'(level_o), prev - 2);
                if (steps > 1)
                    chk(cyc - last == 2*P/CELLS, "R5 peak spacing", cyc - last, 2*P/CELLS);
                last = cyc;
                prev = int'(level_o);
            end
        end
        chk(steps == CELLS, "R3 step count", steps, CELLS);
        chk(level_o == -CELLS, "R9 negative level", int'(level_o), -CELLS);
        chk(gate_o == {CELLS{4'b1100}}, "R1 negative nibbles", int'(gate_o), int'({CELLS{4'b1100}}));

        // R6 / R8: turn-off is immediate on disable
        en = 1'b0;
        @(negedge clk);
        chk(gate_o == '0, "R6 R8 gates off one edge after disable", int'(gate_o), 0);
        chk(level_o == 0, "R8 level zero when disabled", int'(level_o), 0);

        done = 1'b1;
        finish_run();
    end
endmodule